// File: doc/BRIEF.md
# USB Endpoint Interrupt Generator

This block turns per-endpoint transfer events from a USB device protocol engine into sticky interrupt status bits. It serves a controller in which the CPU moves endpoint data itself through registers. The CPU enables endpoints one by one, reads which endpoints have pending work, and acknowledges them by writing ones to a clear register. A single combined interrupt line is raised when any enabled endpoint has a pending bit, or when the externally generated frame interrupt is present and enabled.

Endpoints are physical: an even index is an OUT endpoint and an odd index is an IN endpoint. A per-endpoint isochronous flag suppresses endpoint interrupts completely, because isochronous traffic is serviced from the frame interrupt. Interrupt on NAK can be enabled separately for the OUT endpoints and for the IN endpoints.

Register access goes through a two-state bus sequencer. BUS_IDLE waits for a request. On the edge that samples `bus_req` it captures the access and moves to BUS_ACCESS (transition IDLE_TO_ACCESS). BUS_ACCESS acknowledges for one cycle, presents read data, commits a write on its closing edge, and then always returns to BUS_IDLE (transition ACCESS_TO_IDLE).

Top module: `ep_irq_gen`

## Requirements
- R1: After reset the enable, status and control registers read 0, and `irq` and `bus_ack` are 0.
- R2: A non-isochronous OUT endpoint (even index 2k) sets status bit 2k when `pkt_rx` is pulsed with `pkt_err` low. If `pkt_err` is high in the same cycle, no bit is set.
- R3: A non-isochronous IN endpoint (odd index 2k+1) sets status bit 2k+1 when `pkt_tx` is pulsed.
- R4: A `nak_sent` pulse sets the bit of an IN endpoint only while control bit 1 is 1, and sets the bit of an OUT endpoint only while control bit 0 is 1.
- R5: An endpoint whose `ep_iso` bit is 1 never sets its status bit, whatever its events are.
- R6: Events that do not match the endpoint's direction are ignored: `pkt_tx` on an even index and `pkt_rx` on an odd index set nothing.
- R7: Status bits are sticky. Writing a 1 to a bit of the clear register (address 2) clears that bit. Writing 0 bits has no effect. Reading address 2 returns 0.
- R8: When an event and a clear of the same bit take effect on the same edge, the bit stays set.
- R9: Status bits are readable at address 1 whatever the enables are. `irq` = OR over (status AND enable at address 0), ORed with (`frame_irq` AND control bit 2).
- R10: A request sampled in BUS_IDLE raises `bus_ack` for exactly the next cycle, with valid `bus_rdata` for reads. A write takes effect at the edge that ends that cycle. A request seen during BUS_ACCESS is ignored.
- R11: The register map is: address 0 enable (read/write), address 1 status (read-only, writes ignored), address 2 clear (write-only), address 3 control (bits 2:0, read/write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_rx | input | NUM_EP | Packet received pulse per endpoint |
| pkt_err | input | NUM_EP | Received packet had an error (qualifies pkt_rx) |
| pkt_tx | input | NUM_EP | Packet transmitted pulse per endpoint |
| nak_sent | input | NUM_EP | NAK handshake sent pulse per endpoint |
| ep_iso | input | NUM_EP | Endpoint is isochronous |
| frame_irq | input | 1 | Frame interrupt from frame-timing logic |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | Access acknowledge, one cycle |
| bus_rdata | output | DATA_W | Read data, valid while bus_ack is 1 |
| irq | output | 1 | Combined interrupt line |

## Verification
An event pulse sampled on an edge is visible in status, and through `irq`, right after that same edge. A request sampled on edge A gives `bus_ack` and read data between A and A+1, and a write lands at A+1. The bench drives everything on falling edges and samples on the falling edge after the edge where each result is due. For the clear/event collision, the event is placed so that it is sampled on edge A+1, the same edge that commits the clear.

// File: rtl/ep_irq_pkg.sv
`timescale 1ns/1ps
package ep_irq_pkg;
    typedef enum logic [0:0] {BUS_IDLE = 1'b0, BUS_ACCESS = 1'b1} bus_state_e;

    localparam logic [2:0] ADDR_ENABLE = 3'd0;
    localparam logic [2:0] ADDR_STATUS = 3'd1;
    localparam logic [2:0] ADDR_CLEAR  = 3'd2;
    localparam logic [2:0] ADDR_CTRL   = 3'd3;

    localparam int CTRL_W      = 3;
    localparam int CTRL_NAKOUT = 0;
    localparam int CTRL_NAKIN  = 1;
    localparam int CTRL_FRAME  = 2;
endpackage

// File: rtl/ep_irq_bus_fsm.sv
`timescale 1ns/1ps
module ep_irq_bus_fsm
    import ep_irq_pkg::*;
#(
    parameter int NUM_EP = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NUM_EP-1:0] status_i,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_EP-1:0] enable_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [NUM_EP-1:0] clr_o
);
    bus_state_e        state_q, state_d;
    logic              cap_we_q;
    logic [2:0]        cap_addr_q;
    logic [DATA_W-1:0] cap_wdata_q;
    logic [NUM_EP-1:0] enable_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              en_we, ctrl_we;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // next state: IDLE_TO_ACCESS on request, ACCESS_TO_IDLE always
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:   if (bus_req) state_d = BUS_ACCESS;
            BUS_ACCESS: state_d = BUS_IDLE;
        endcase
    end

    // access capture, only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_we_q    <= 1'b0;
            cap_addr_q  <= '0;
            cap_wdata_q <= '0;
        end else if (state_q == BUS_IDLE && bus_req) begin
            cap_we_q    <= bus_we;
            cap_addr_q  <= bus_addr;
            cap_wdata_q <= bus_wdata;
        end
    end

    // outputs of the access state
    always_comb begin
        bus_ack   = 1'b0;
        bus_rdata = '0;
        clr_o     = '0;
        en_we     = 1'b0;
        ctrl_we   = 1'b0;
        unique case (state_q)
            BUS_IDLE: ;
            BUS_ACCESS: begin
                bus_ack = 1'b1;
                if (cap_we_q) begin
                    case (cap_addr_q)
                        ADDR_ENABLE: en_we   = 1'b1;
                        ADDR_CLEAR:  clr_o   = cap_wdata_q[NUM_EP-1:0];
                        ADDR_CTRL:   ctrl_we = 1'b1;
                        default: ;
                    endcase
                end else begin
                    case (cap_addr_q)
                        ADDR_ENABLE: bus_rdata = DATA_W'(enable_q);
                        ADDR_STATUS: bus_rdata = DATA_W'(status_i);
                        ADDR_CTRL:   bus_rdata = DATA_W'(ctrl_q);
                        default:     bus_rdata = '0;
                    endcase
                end
            end
        endcase
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            ctrl_q   <= '0;
        end else begin
            if (en_we)   enable_q <= cap_wdata_q[NUM_EP-1:0];
            if (ctrl_we) ctrl_q   <= cap_wdata_q[CTRL_W-1:0];
        end
    end

    assign enable_o = enable_q;
    assign ctrl_o   = ctrl_q;

    // R10: acknowledge lasts one cycle
    p_ack_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R10: no acknowledge without a request sampled one edge earlier
    p_ack_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bus_req)) |-> !bus_ack);
endmodule

// File: rtl/ep_irq_qual.sv
`timescale 1ns/1ps
module ep_irq_qual #(
    parameter int NUM_EP = 32
) (
    input  logic [NUM_EP-1:0] pkt_rx,
    input  logic [NUM_EP-1:0] pkt_err,
    input  logic [NUM_EP-1:0] pkt_tx,
    input  logic [NUM_EP-1:0] nak_sent,
    input  logic [NUM_EP-1:0] ep_iso,
    input  logic              nak_out_en,
    input  logic              nak_in_en,
    output logic [NUM_EP-1:0] set_o
);
    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        localparam bit IS_OUT = ((i % 2) == 0);
        logic data_evt, nak_evt;
        assign data_evt = IS_OUT ? (pkt_rx[i] & ~pkt_err[i]) : pkt_tx[i];
        assign nak_evt  = nak_sent[i] & (IS_OUT ? nak_out_en : nak_in_en);
        assign set_o[i] = ~ep_iso[i] & (data_evt | nak_evt);
    end
endmodule

// File: rtl/ep_irq_status.sv
`timescale 1ns/1ps
module ep_irq_status #(
    parameter int NUM_EP = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] set_i,
    input  logic [NUM_EP-1:0] clr_i,
    input  logic [NUM_EP-1:0] enable_i,
    input  logic              frame_irq,
    input  logic              frame_en,
    output logic [NUM_EP-1:0] status_o,
    output logic              irq
);
    logic [NUM_EP-1:0] st_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr_i) | set_i;
    end

    assign status_o = st_q;
    assign irq      = (|(st_q & enable_i)) | (frame_irq & frame_en);

    // R7: a set bit only drops when it was cleared
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st_q) & ~$past(clr_i) & ~st_q) == '0));

    // R8: an event always leaves its bit set, even against a clear
    p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(set_i) & ~st_q) == '0));
endmodule

// File: rtl/ep_irq_gen.sv
`timescale 1ns/1ps
module ep_irq_gen
    import ep_irq_pkg::*;
#(
    parameter int NUM_EP = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] pkt_rx,
    input  logic [NUM_EP-1:0] pkt_err,
    input  logic [NUM_EP-1:0] pkt_tx,
    input  logic [NUM_EP-1:0] nak_sent,
    input  logic [NUM_EP-1:0] ep_iso,
    input  logic              frame_irq,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [NUM_EP-1:0] status_w, enable_w, clr_w, set_w;
    logic [CTRL_W-1:0] ctrl_w;

    ep_irq_bus_fsm #(.NUM_EP(NUM_EP), .DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .status_i(status_w),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .enable_o(enable_w), .ctrl_o(ctrl_w), .clr_o(clr_w)
    );

    ep_irq_qual #(.NUM_EP(NUM_EP)) u_qual (
        .pkt_rx(pkt_rx), .pkt_err(pkt_err), .pkt_tx(pkt_tx),
        .nak_sent(nak_sent), .ep_iso(ep_iso),
        .nak_out_en(ctrl_w[CTRL_NAKOUT]), .nak_in_en(ctrl_w[CTRL_NAKIN]),
        .set_o(set_w)
    );

    ep_irq_status #(.NUM_EP(NUM_EP)) u_status (
        .clk(clk), .rst_n(rst_n),
        .set_i(set_w), .clr_i(clr_w), .enable_i(enable_w),
        .frame_irq(frame_irq), .frame_en(ctrl_w[CTRL_FRAME]),
        .status_o(status_w), .irq(irq)
    );

    // R5: an isochronous endpoint never gains a status bit
    p_iso_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_w & ~$past(status_w) & $past(ep_iso)) == '0));

    // R9: interrupt line low when nothing enabled is pending and frame path is off
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (((status_w & enable_w) == '0) && !(frame_irq && ctrl_w[CTRL_FRAME])) |-> !irq);
endmodule

// File: tb/ep_irq_gen_tb_top.sv
`timescale 1ns/1ps
module ep_irq_gen_tb_top;
    localparam int N = 32;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] pkt_rx = '0, pkt_err = '0, pkt_tx = '0, nak_sent = '0;
    logic [N-1:0] ep_iso = 32'h0000_0030;
    logic frame_irq = 1'b0;
    logic bus_req = 1'b0, bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic bus_ack, irq;
    logic [W-1:0] bus_rdata;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ep_irq_gen #(.NUM_EP(N), .DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .pkt_rx(pkt_rx), .pkt_err(pkt_err), .pkt_tx(pkt_tx),
        .nak_sent(nak_sent), .ep_iso(ep_iso), .frame_irq(frame_irq),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", rq, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        @(posedge clk);
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
        @(posedge clk);
    endtask

    task automatic pulse(input logic [N-1:0] rx, input logic [N-1:0] er,
                         input logic [N-1:0] tx, input logic [N-1:0] nk);
        @(negedge clk);
        pkt_rx = rx; pkt_err = er; pkt_tx = tx; nak_sent = nk;
        @(posedge clk);
        @(negedge clk);
        pkt_rx = '0; pkt_err = '0; pkt_tx = '0; nak_sent = '0;
    endtask

    task automatic read_status(input string rq, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(3'd1, d);
        chk(rq, "status", d, exp);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        chk("R1", "irq after reset", {31'b0, irq}, 32'h0);
        chk("R1", "ack after reset", {31'b0, bus_ack}, 32'h0);
        bus_read(3'd0, d); chk("R1", "enable reset", d, 32'h0);
        bus_read(3'd1, d); chk("R1", "status reset", d, 32'h0);
        bus_read(3'd3, d); chk("R1", "ctrl reset", d, 32'h0);
    endtask

    task automatic t_out_rx();
        pulse(32'h4, 32'h0, 32'h0, 32'h0);
        read_status("R2", 32'h4);
        pulse(32'h40, 32'h40, 32'h0, 32'h0);
        read_status("R2", 32'h4);
        bus_write(3'd2, 32'hFFFF_FFFF);
    endtask

    task automatic t_in_tx();
        pulse(32'h0, 32'h0, 32'h8, 32'h0);
        read_status("R3", 32'h8);
        bus_write(3'd2, 32'hFFFF_FFFF);
    endtask

    task automatic t_nak();
        pulse(32'h0, 32'h0, 32'h0, 32'h3);
        read_status("R4", 32'h0);
        bus_write(3'd3, 32'h2);
        pulse(32'h0, 32'h0, 32'h0, 32'h3);
        read_status("R4", 32'h2);
        bus_write(3'd2, 32'hFFFF_FFFF);
        bus_write(3'd3, 32'h1);
        pulse(32'h0, 32'h0, 32'h0, 32'h3);
        read_status("R4", 32'h1);
        bus_write(3'd2, 32'hFFFF_FFFF);
        bus_write(3'd3, 32'h0);
    endtask

    task automatic t_iso();
        bus_write(3'd3, 32'h3);
        pulse(32'h10, 32'h0, 32'h20, 32'h30);
        read_status("R5", 32'h0);
        bus_write(3'd3, 32'h0);
    endtask

    task automatic t_wrong_dir();
        pulse(32'h200, 32'h0, 32'h100, 32'h0);
        read_status("R6", 32'h0);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        pulse(32'h4, 32'h0, 32'h8, 32'h0);
        read_status("R7", 32'hC);
        bus_write(3'd2, 32'h4);
        read_status("R7", 32'h8);
        bus_write(3'd2, 32'h0);
        read_status("R7", 32'h8);
        bus_read(3'd2, d); chk("R7", "clear reads zero", d, 32'h0);
        bus_write(3'd2, 32'h8);
        read_status("R7", 32'h0);
    endtask

    task automatic t_race();
        pulse(32'h400, 32'h0, 32'h0, 32'h0);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h400;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        pkt_rx = 32'h400;
        @(posedge clk);
        @(negedge clk);
        pkt_rx = '0;
        read_status("R8", 32'h400);
        bus_write(3'd2, 32'h400);
        read_status("R8", 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        pulse(32'h400, 32'h0, 32'h0, 32'h0);
        chk("R9", "irq masked", {31'b0, irq}, 32'h0);
        read_status("R9", 32'h400);
        bus_write(3'd0, 32'h400);
        @(negedge clk);
        chk("R9", "irq enabled", {31'b0, irq}, 32'h1);
        bus_write(3'd0, 32'h800);
        @(negedge clk);
        chk("R9", "irq other enable", {31'b0, irq}, 32'h0);
        frame_irq = 1'b1;
        @(negedge clk);
        chk("R9", "frame masked", {31'b0, irq}, 32'h0);
        bus_write(3'd3, 32'h4);
        @(negedge clk);
        chk("R9", "frame enabled", {31'b0, irq}, 32'h1);
        frame_irq = 1'b0;
        @(negedge clk);
        chk("R9", "frame dropped", {31'b0, irq}, 32'h0);
        bus_read(3'd3, d); chk("R11", "ctrl readback", d, 32'h4);
        bus_write(3'd3, 32'h0);
        bus_write(3'd2, 32'hFFFF_FFFF);
        bus_write(3'd0, 32'h0);
    endtask

    task automatic t_bus();
        logic [31:0] d;
        // read timing
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 3'd0;
        chk("R10", "no ack before edge", {31'b0, bus_ack}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0;
        chk("R10", "ack after req", {31'b0, bus_ack}, 32'h1);
        @(posedge clk);
        @(negedge clk);
        chk("R10", "ack one cycle", {31'b0, bus_ack}, 32'h0);
        // held request: second cycle ignored
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h11;
        @(posedge clk);
        @(negedge clk);
        bus_wdata = 32'h22;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        chk("R10", "no ack for held req", {31'b0, bus_ack}, 32'h0);
        bus_read(3'd0, d); chk("R10", "held req write", d, 32'h11);
        // status register is read-only
        pulse(32'h1, 32'h0, 32'h0, 32'h0);
        bus_write(3'd1, 32'h0);
        read_status("R11", 32'h1);
        bus_write(3'd1, 32'hF0);
        read_status("R11", 32'h1);
        bus_write(3'd2, 32'hFFFF_FFFF);
        bus_write(3'd0, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_out_rx();
        t_in_tx();
        t_nak();
        t_iso();
        t_wrong_dir();
        t_clear();
        t_race();
        t_irq();
        t_bus();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule